// File: doc/BRIEF.md
# Peripheral Clock Prescaler Bank

This block produces the clock-enable strobes that time a chip's peripherals. It works on one fast system clock. Every slower clock arrives as a one-cycle tick, and every output is a one-cycle enable strobe. Three sources are offered as ticks: the main clock, the PLL clock and the on-chip oscillator. Two select bits pick one of them as the peripheral base tick. The bank divides that base tick by 1, 8 and 32 into `f1_en`, `f8_en` and `f32_en`, and passes it undivided as the A/D converter enable `fad_en`.

A second prescaler produces `f2n_en`. It runs from its own source, chosen by a 2-bit code among the base tick, the crystal-input tick and the oscillator tick. It divides that source by 2n, where n is a 4-bit value. When n is 0 the source passes straight through.

All five strobes are suppressed in two cases: low-power mode, and wait mode entered while the peripheral-stop bit is set. The prescaler counters count only the ticks that get through. They therefore freeze while the bank is stopped and continue cleanly afterwards.

Top module: `periph_clk_prescaler`

## Requirements
- R1: After each cycle with a gated base tick, `f1_en` is high for exactly one cycle, one clock later. In every other cycle it is low.
- R2: `f8_en` fires on every 8th gated base tick and `f32_en` on every 32nd, counted from reset. Both appear with one clock of latency, and each coincides with `f1_en` (and `f32_en` with `f8_en`).
- R3: The base tick is `oco_tick` when `oco_sel`=1. Otherwise it is `pll_tick` when `pll_sel`=1, and `main_tick` when both bits are 0.
- R4: `fad_en` is the selected base tick (main, PLL or oscillator), gated and undivided, with one clock of latency.
- R5: The f2n source code on `f2n_src` is 0 for the base tick, 1 for `xin_tick` and 2 for `oco_tick`.
- R6: With a division value n of 0, every f2n source tick gives a strobe. With n from 1 to 15, one strobe is given per 2n source ticks.
- R7: Source code 3 gives no f2n strobes, and the f2n counter holds its position.
- R8: In a cycle where `low_power`=1, or where `wait_mode`=1 and `stop_in_wait`=1, no input tick produces any strobe. Wait mode with `stop_in_wait`=0 does not stop the strobes.
- R9: Ticks blocked by R8 do not advance either prescaler. Counting resumes from the held position with no shortened period.
- R10: A new `f2n_div` value is taken only on the tick that completes an f2n period. After reset, the first f2n source tick completes a period: it gives a strobe and loads the division value.
- R11: During reset all five strobes are low, and both prescalers restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | Main clock tick |
| pll_tick | input | 1 | PLL clock tick |
| pll_sel | input | 1 | Selects PLL over main for the base tick and fAD |
| oco_sel | input | 1 | Selects the on-chip oscillator for the base tick and fAD |
| oco_tick | input | 1 | On-chip oscillator tick |
| xin_tick | input | 1 | Crystal-input clock tick |
| f2n_src | input | 2 | f2n source code (0 base, 1 crystal, 2 oscillator, 3 none) |
| f2n_div | input | 4 | f2n division value n |
| stop_in_wait | input | 1 | Peripheral clocks stop in wait mode |
| wait_mode | input | 1 | Device is in wait mode |
| low_power | input | 1 | Device is in low-power mode |
| f1_en | output | 1 | Base tick divided by 1 |
| f8_en | output | 1 | Base tick divided by 8 |
| f32_en | output | 1 | Base tick divided by 32 |
| f2n_en | output | 1 | f2n source divided by 2n |
| fad_en | output | 1 | A/D converter clock enable |

## Verification
The four source ticks run at four different fixed rates: every cycle, every 2nd, two cycles in three, and every 5th. Because the rates differ, a wrong source selection shows up as a wrong strobe rate.

Each base-select combination is run under four gating states: free running, wait mode without the stop bit, wait mode with the stop bit, and low power. This separates the two stop conditions from each other and from the harmless one.

The f2n prescaler is swept over every source code and every division value without a reset in between, with stop windows placed inside each run. This exercises counter hold, resume and the rule that a new division value waits for a wrap.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  typedef enum logic [1:0] {
    SRC_BASE = 2'd0,
    SRC_XIN  = 2'd1,
    SRC_OCO  = 2'd2,
    SRC_NONE = 2'd3
  } f2n_src_e;

  function automatic logic clocks_run(input logic lp, input logic wm, input logic stop_bit);
    return !(lp || (wm && stop_bit));
  endfunction
endpackage

// File: rtl/pcp_tick_select.sv
module pcp_tick_select
  import pcp_pkg::*;
(
  input  logic     main_tick,
  input  logic     pll_tick,
  input  logic     oco_tick,
  input  logic     xin_tick,
  input  logic     pll_sel,
  input  logic     oco_sel,
  input  logic [1:0] src,
  input  logic     run,
  output logic     base_g,
  output logic     f2n_g
);
  logic main_path;
  logic base_raw;
  logic f2n_raw;

  assign main_path = pll_sel ? pll_tick : main_tick;
  assign base_raw  = oco_sel ? oco_tick : main_path;

  always_comb begin
    unique case (f2n_src_e'(src))
      SRC_BASE: f2n_raw = base_raw;
      SRC_XIN:  f2n_raw = xin_tick;
      SRC_OCO:  f2n_raw = oco_tick;
      default:  f2n_raw = 1'b0;
    endcase
  end

  assign base_g = base_raw && run;
  assign f2n_g  = f2n_raw && run;
endmodule

// File: rtl/pcp_fixed_div.sv
module pcp_fixed_div #(
  parameter int MID_LOG = 3,
  parameter int TOP_LOG = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic f1_en,
  output logic fmid_en,
  output logic ftop_en
);
  logic [TOP_LOG-1:0] cnt;
  logic               mid_hit;
  logic               top_hit;

  assign mid_hit = tick && (&cnt[MID_LOG-1:0]);
  assign top_hit = tick && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      f1_en   <= 1'b0;
      fmid_en <= 1'b0;
      ftop_en <= 1'b0;
    end else begin
      f1_en   <= tick;
      fmid_en <= mid_hit;
      ftop_en <= top_hit;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  assert_mid_with_f1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fmid_en |-> f1_en);
  assert_top_with_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ftop_en |-> fmid_en);
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/pcp_even_div.sv
module pcp_even_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             strobe
);
  localparam int CNT_W = DIV_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             wrap;

  assign last = {div_q, 1'b0} - ONE;
  assign wrap = tick && ((div_q == '0) || (cnt == last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= wrap;
      if (tick) begin
        if (wrap) begin
          cnt   <= '0;
          div_q <= div;
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != '0) |-> (cnt < {div_q, 1'b0}));
  assert_div_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(div_q));
  assert_no_strobe_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !strobe);
endmodule

// File: rtl/periph_clk_prescaler.sv
module periph_clk_prescaler
  import pcp_pkg::*;
#(
  parameter int MID_LOG = 3,
  parameter int TOP_LOG = 5,
  parameter int DIV_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             main_tick,
  input  logic             pll_tick,
  input  logic             pll_sel,
  input  logic             oco_sel,
  input  logic             oco_tick,
  input  logic             xin_tick,
  input  logic [1:0]       f2n_src,
  input  logic [DIV_W-1:0] f2n_div,
  input  logic             stop_in_wait,
  input  logic             wait_mode,
  input  logic             low_power,
  output logic             f1_en,
  output logic             f8_en,
  output logic             f32_en,
  output logic             f2n_en,
  output logic             fad_en
);
  logic run;
  logic base_g;
  logic f2n_g;

  assign run = clocks_run(low_power, wait_mode, stop_in_wait);

  pcp_tick_select u_sel (
    .main_tick (main_tick),
    .pll_tick  (pll_tick),
    .oco_tick  (oco_tick),
    .xin_tick  (xin_tick),
    .pll_sel   (pll_sel),
    .oco_sel   (oco_sel),
    .src       (f2n_src),
    .run       (run),
    .base_g    (base_g),
    .f2n_g     (f2n_g)
  );

  pcp_fixed_div #(.MID_LOG(MID_LOG), .TOP_LOG(TOP_LOG)) u_fix (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (base_g),
    .f1_en   (f1_en),
    .fmid_en (f8_en),
    .ftop_en (f32_en)
  );

  pcp_even_div #(.DIV_W(DIV_W)) u_f2n (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (f2n_g),
    .div    (f2n_div),
    .strobe (f2n_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fad_en <= 1'b0;
    else        fad_en <= base_g;
  end

  assert_low_power_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |=> !(f1_en || f8_en || f32_en || f2n_en || fad_en));
  assert_wait_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mode && stop_in_wait) |=> !(f1_en || f2n_en || fad_en));
  assert_reserved_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (f2n_src == 2'd3) |=> !f2n_en);
  assert_oco_fad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (oco_sel && !oco_tick) |=> !fad_en);
endmodule

// File: tb/periph_clk_prescaler_test.sv
module periph_clk_prescaler_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic main_tick, pll_tick, pll_sel, oco_sel, oco_tick, xin_tick;
  logic [1:0] f2n_src;
  logic [3:0] f2n_div;
  logic stop_in_wait, wait_mode, low_power;
  logic f1_en, f8_en, f32_en, f2n_en, fad_en;

  periph_clk_prescaler uut (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .pll_tick(pll_tick),
    .pll_sel(pll_sel), .oco_sel(oco_sel), .oco_tick(oco_tick), .xin_tick(xin_tick),
    .f2n_src(f2n_src), .f2n_div(f2n_div), .stop_in_wait(stop_in_wait),
    .wait_mode(wait_mode), .low_power(low_power), .f1_en(f1_en), .f8_en(f8_en),
    .f32_en(f32_en), .f2n_en(f2n_en), .fad_en(fad_en)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int fcnt = 0;
  int c2 = 0;
  int act = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s cycle=%0d actual=%0b expected=%0b", tag, cyc, got, exp);
    end
  endtask

  task automatic step();
    bit run, b, s, bg, sg, e1, e8, e32, e2n;
    main_tick = (cyc % 2 == 0);
    pll_tick  = 1'b1;
    xin_tick  = (cyc % 3 != 1);
    oco_tick  = (cyc % 5 == 0);
    run = !(low_power || (wait_mode && stop_in_wait));
    b = oco_sel ? oco_tick : (pll_sel ? pll_tick : main_tick);
    case (f2n_src)
      2'd0: s = b;
      2'd1: s = xin_tick;
      2'd2: s = oco_tick;
      default: s = 0;
    endcase
    bg = b && run;
    sg = s && run;
    e8 = 0; e32 = 0; e2n = 0;
    if (rst_n) begin
      if (bg) begin
        fcnt++;
        e8 = (fcnt % 8 == 0);
        e32 = (fcnt % 32 == 0);
      end
      if (sg) begin
        if (act == 0) begin
          e2n = 1; act = f2n_div;
        end else begin
          c2++;
          if (c2 == 2 * act) begin
            e2n = 1; c2 = 0; act = f2n_div;
          end
        end
      end
    end
    e1 = rst_n && bg;
    @(posedge clk);
    @(negedge clk);
    if (!rst_n) begin
      chk("R11 f1", f1_en, 0); chk("R11 f8", f8_en, 0); chk("R11 f32", f32_en, 0);
      chk("R11 f2n", f2n_en, 0); chk("R11 fad", fad_en, 0);
    end else begin
      chk(run ? "R1/R3 f1" : "R8 f1", f1_en, e1);
      chk(run ? "R2 f8" : "R8 f8", f8_en, e8);
      chk(run ? "R2 f32" : "R9 f32", f32_en, e32);
      chk(run ? "R4 fad" : "R8 fad", fad_en, e1);
      if (f2n_src == 2'd3) chk("R7 f2n", f2n_en, e2n);
      else chk(run ? "R6/R5/R10 f2n" : "R9 f2n", f2n_en, e2n);
    end
    cyc++;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pll_sel = 0; oco_sel = 0; f2n_src = 0; f2n_div = 4'd3;
    stop_in_wait = 0; wait_mode = 0; low_power = 0;
    main_tick = 0; pll_tick = 0; oco_tick = 0; xin_tick = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) step();   // R11 reset state
    rst_n = 1;
    // R1 R2 R3 R4 R8: base selection under each gating state
    for (int sel = 0; sel < 3; sel++) begin
      pll_sel = (sel == 1);
      oco_sel = (sel == 2);
      for (int g = 0; g < 4; g++) begin
        wait_mode = (g == 1 || g == 2);
        stop_in_wait = (g == 2);
        low_power = (g == 3);
        for (int i = 0; i < 120; i++) step();
      end
    end
    wait_mode = 0; stop_in_wait = 0; low_power = 0;
    pll_sel = 0; oco_sel = 0;
    // R5 R6 R7 R9 R10: f2n sweep without reset, stop windows inside each run
    for (int sc = 0; sc < 4; sc++) begin
      f2n_src = 2'(sc);
      for (int d = 0; d < 16; d++) begin
        f2n_div = 4'(d);
        for (int i = 0; i < 100; i++) begin
          low_power = (i >= 40 && i < 50);
          wait_mode = (i >= 70 && i < 76);
          stop_in_wait = (i >= 70 && i < 74);
          step();
        end
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule